// File: doc/BRIEF.md
# Control-Register Space Decoder

This block sits between a 32-bit control-register bus and a set of on-chip peripheral register banks. Each request carries a valid strobe, a write enable, an address, an access size and write data. The decoder ignores the top three address bits and picks a bank from the bits that remain. It then checks the offset against that bank's own read or write limit, and selects a word-aligned slot inside the bank. Read data and an error flag come back one clock after the request.

Every slot has an access class: no-access, constant or plain storage. Storage slots take byte, halfword and word writes; a narrow write leaves the untouched bits of the slot as they were. Constant slots always hold their reset value. Two further address windows are write-only: writes to them are accepted and change nothing, and reads from them return zero. The peripherals behind the banks are outside this block. Slots that would be backed by a peripheral handler are modelled here as plain storage.

Top module: `ctlreg_decoder`

## Requirements
- R1: The bank is selected by address bits 28:16 alone. Addresses that differ only in bits 31:29 (for example 0xFF000000 and 0x1F000000) reach the same bank and the same slot.
- R2: Within a bank, the slot index is address bits 7:2, and distinct indices hold independent values. Defaults: bank 0 has key 0x1F00, bank 1 has key 0x1FD0, bank 2 has key 0x1FD8.
- R3: Each bank has its own read limit and its own write limit, compared against address bits 15:0. Defaults: bank 0 reads up to 0x44 and writes up to 0x3C; bank 1 reads up to 0x10 and writes up to 0x0C; bank 2 reads and writes up to 0x2C.
- R4: An access above the applicable limit, or to a key that matches no bank and no write-only window, sets the error flag. For a read it returns zero; for a write it changes no slot.
- R5: A no-access slot (default: bank 0, offset 0x04) reads as zero and discards writes, without raising an error.
- R6: A constant slot (default: bank 0, offset 0x08) always reads its reset value and ignores writes.
- R7: Size code 2 is a 32-bit access, code 1 uses bits 15:0 and code 0 uses bits 7:0. A narrow read is zero-extended. A narrow write keeps the slot's other bits.
- R8: The write-only windows (default keys 0x1F90 and 0x1F94) accept writes without error and without stored effect, and read as zero without error.
- R9: Read data and the error flag are registered and belong to the request sampled at the previous rising edge. In a cycle after no request, both are zero.
- R10: The reset value of a non-no-access slot is 0xC0DE0000 OR (bank number << 8) OR slot index. Asserting reset restores every storage slot to this value and clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address |
| size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| wdata | input | 32 | Write data, low bits used for narrow sizes |
| rd_data | output | 32 | Read result, one cycle after the request |
| err_o | output | 1 | Out-of-range or unknown-bank flag, aligned with rd_data |

## Verification
Word writes and reads through aliased upper address bits show that bits 31:29 play no part in the decode, and accesses to neighbouring slots show that each slot index is independent. Offsets that lie between a bank's write limit and its read limit separate the read bound from the write bound. Offsets just past the read limit, or with bits 15:8 set, together with unknown keys, exercise the error path. Halfword and byte writes over a known word expose any corruption of the preserved bits. Accesses to the no-access slot, the constant slot and the write-only windows, followed by read-back and a reset issued in the middle of the run, show that the discarded writes really changed nothing and that stored values are restored.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int KEY_W  = 13;
  localparam int SLOT_W = 6;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  // Lane mask for an access size; unknown code treated as a full word
  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      ACC_BYTE: size_mask = 32'h0000_00FF;
      ACC_HALF: size_mask = 32'h0000_FFFF;
      default:  size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  // Write merge: only the lanes of the access size change
  function automatic logic [31:0] merge_write(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [1:0]  sz);
    logic [31:0] m;
    m = size_mask(sz);
    merge_write = (old_v & ~m) | (new_v & m);
  endfunction

  // Zero-extended narrow read
  function automatic logic [31:0] narrow_read(input logic [31:0] v,
                                              input logic [1:0]  sz);
    narrow_read = v & size_mask(sz);
  endfunction

  function automatic logic [KEY_W-1:0] bank_key(input logic [28:0] a);
    bank_key = a[28:16];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [28:0] a);
    slot_of = a[7:2];
  endfunction

  // Reset word of a slot
  function automatic logic [31:0] slot_init(input logic [31:0] base,
                                            input int bank,
                                            input int slot);
    slot_init = base | (32'(bank) << 8) | 32'(slot);
  endfunction

endpackage

// File: rtl/ctlreg_bank_sel.sv
module ctlreg_bank_sel
  import ctlreg_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int NWO   = 2,
  parameter int NSLOT = 18,
  parameter logic [NBANK-1:0][KEY_W-1:0] BANK_KEY = {13'h1FD8, 13'h1FD0, 13'h1F00},
  parameter logic [NWO-1:0][KEY_W-1:0]   WO_KEY   = {13'h1F94, 13'h1F90},
  parameter logic [NBANK-1:0][7:0]       RD_LIMIT = {8'h2C, 8'h10, 8'h44},
  parameter logic [NBANK-1:0][7:0]       WR_LIMIT = {8'h2C, 8'h0C, 8'h3C},
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [28:0]   addr_lo,
  output logic          bank_hit,
  output logic [BW-1:0] bank_idx,
  output logic          wo_hit,
  output logic          rd_in,
  output logic          wr_in
);

  logic [KEY_W-1:0]  key;
  logic [SLOT_W-1:0] slot;
  logic [7:0]        rd_lim;
  logic [7:0]        wr_lim;
  logic              slot_ok;

  assign key     = bank_key(addr_lo);
  assign slot    = slot_of(addr_lo);
  assign slot_ok = (32'(slot) < NSLOT);

  always_comb begin
    bank_hit = 1'b0;
    bank_idx = '0;
    rd_lim   = '0;
    wr_lim   = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (key == BANK_KEY[i]) begin
        bank_hit = 1'b1;
        bank_idx = BW'(i);
        rd_lim   = RD_LIMIT[i];
        wr_lim   = WR_LIMIT[i];
      end
    end
  end

  always_comb begin
    wo_hit = 1'b0;
    for (int j = 0; j < NWO; j++) begin
      if (key == WO_KEY[j]) wo_hit = 1'b1;
    end
  end

  assign rd_in = bank_hit && slot_ok && (addr_lo[15:0] <= {8'h00, rd_lim});
  assign wr_in = bank_hit && slot_ok && (addr_lo[15:0] <= {8'h00, wr_lim});

endmodule

// File: rtl/ctlreg_slot_bank.sv
module ctlreg_slot_bank
  import ctlreg_pkg::*;
#(
  parameter int          NSLOT    = 18,
  parameter int          BANK_ID  = 0,
  parameter logic [63:0] NOACC    = 64'h0,
  parameter logic [63:0] CONSTS   = 64'h0,
  parameter logic [31:0] RST_BASE = 32'hC0DE_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        wr_size,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_value
);

  logic [NSLOT-1:0][31:0] cells;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [31:0] INIT = slot_init(RST_BASE, BANK_ID, s);
    if (NOACC[s]) begin : g_none
      assign cells[s] = 32'h0;
    end else if (CONSTS[s]) begin : g_const
      assign cells[s] = INIT;
    end else begin : g_store
      logic [31:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cell_q <= INIT;
        else if (wr_en && slot == SLOT_W'(s))
          cell_q <= merge_write(cell_q, wr_data, wr_size);
      end
      assign cells[s] = cell_q;
    end
  end

  always_comb begin
    rd_value = 32'h0;
    for (int s = 0; s < NSLOT; s++) begin
      if (slot == SLOT_W'(s)) rd_value = cells[s];
    end
  end

endmodule

// File: rtl/ctlreg_decoder.sv
module ctlreg_decoder
  import ctlreg_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int NWO   = 2,
  parameter int NSLOT = 18,
  parameter logic [NBANK-1:0][KEY_W-1:0] BANK_KEY  = {13'h1FD8, 13'h1FD0, 13'h1F00},
  parameter logic [NWO-1:0][KEY_W-1:0]   WO_KEY    = {13'h1F94, 13'h1F90},
  parameter logic [NBANK-1:0][7:0]       RD_LIMIT  = {8'h2C, 8'h10, 8'h44},
  parameter logic [NBANK-1:0][7:0]       WR_LIMIT  = {8'h2C, 8'h0C, 8'h3C},
  parameter logic [NBANK-1:0][63:0]      NOACC_MAP = {64'h0, 64'h0, 64'h2},
  parameter logic [NBANK-1:0][63:0]      CONST_MAP = {64'h0, 64'h0, 64'h4},
  parameter logic [31:0]                 RST_BASE  = 32'hC0DE_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic [31:0] rd_data,
  output logic        err_o
);

  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [28:0]   addr_lo;
  logic          bank_hit;
  logic [BW-1:0] bank_idx;
  logic          wo_hit;
  logic          rd_in;
  logic          wr_in;
  logic          wr_commit;
  logic          rd_commit;
  logic          bad_access;
  logic [31:0]   sel_value;
  logic [31:0]   bank_rd [NBANK];
  logic [4:0]    unused_addr;

  assign addr_lo     = addr[28:0];
  assign unused_addr = {addr[31:29], addr[1:0]};

  ctlreg_bank_sel #(
    .NBANK(NBANK), .NWO(NWO), .NSLOT(NSLOT),
    .BANK_KEY(BANK_KEY), .WO_KEY(WO_KEY),
    .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT)
  ) u_sel (
    .addr_lo (addr_lo),
    .bank_hit(bank_hit),
    .bank_idx(bank_idx),
    .wo_hit  (wo_hit),
    .rd_in   (rd_in),
    .wr_in   (wr_in)
  );

  // Named events for the checker
  assign wr_commit  = req_valid && we && wr_in;
  assign rd_commit  = req_valid && !we && rd_in;
  assign bad_access = req_valid && !wo_hit && (we ? !wr_in : !rd_in);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ctlreg_slot_bank #(
      .NSLOT(NSLOT), .BANK_ID(b),
      .NOACC(NOACC_MAP[b]), .CONSTS(CONST_MAP[b]),
      .RST_BASE(RST_BASE)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_commit && bank_idx == BW'(b)),
      .slot    (slot_of(addr_lo)),
      .wr_size (size),
      .wr_data (wdata),
      .rd_value(bank_rd[b])
    );
  end

  always_comb begin
    sel_value = 32'h0;
    for (int b = 0; b < NBANK; b++) begin
      if (bank_idx == BW'(b)) sel_value = bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= 32'h0;
      err_o   <= 1'b0;
    end else begin
      rd_data <= rd_commit ? narrow_read(sel_value, size) : 32'h0;
      err_o   <= bad_access;
    end
  end

endmodule

// File: rtl/ctlreg_decoder_chk.sv
module ctlreg_decoder_chk
  import ctlreg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        we,
  input logic [1:0]  size,
  input logic [31:0] rd_data,
  input logic        err_o,
  input logic        bank_hit,
  input logic        wo_hit,
  input logic        wr_commit,
  input logic        bad_access
);

  // R4: an errored response carries no data
  p_err_zero_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> rd_data == 32'h0);

  // R4: a rejected access never commits a write
  p_bad_no_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> !wr_commit);

  // R4: unknown key raises the flag on the next cycle
  p_unknown_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bank_hit && !wo_hit) |=> err_o);

  // R8: write-only windows read zero, no error
  p_wo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wo_hit) |=> (rd_data == 32'h0 && !err_o));

  // R9: nothing on the outputs after an idle cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (rd_data == 32'h0 && !err_o));

  // R7: byte read is zero-extended
  p_byte_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !we && size == ACC_BYTE) |=> rd_data[31:8] == 24'h0);

endmodule

bind ctlreg_decoder ctlreg_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .we        (we),
  .size      (size),
  .rd_data   (rd_data),
  .err_o     (err_o),
  .bank_hit  (bank_hit),
  .wo_hit    (wo_hit),
  .wr_commit (wr_commit),
  .bad_access(bad_access)
);

// File: tb/ctlreg_decoder_tb_top.sv
module ctlreg_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        we = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = 2'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic sampled = 1'b0;

  typedef struct {
    logic [31:0] d;
    bit          e;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;  // 200 MHz

  ctlreg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .we(we),
    .addr(addr), .size(size), .wdata(wdata),
    .rd_data(rd_data), .err_o(err_o)
  );

  // Expected reset word, stated from R10
  function automatic logic [31:0] init_of(int bank, int slot);
    return {16'hC0DE, 8'(bank), 8'(slot)};
  endfunction

  task automatic check(string tag, logic [31:0] d, bit e, logic [31:0] xd, bit xe);
    checks++;
    if (d !== xd || e !== xe) begin
      fails++;
      $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b", tag, d, e, xd, xe);
    end
  endtask

  // Driver: one request per cycle, expectation pushed to the scoreboard
  task automatic issue(bit w, logic [31:0] a, logic [1:0] sz, logic [31:0] d,
                       logic [31:0] xd, bit xe, string tag);
    exp_t x;
    @(negedge clk);
    req_valid = 1'b1; we = w; addr = a; size = sz; wdata = d;
    x.d = xd; x.e = xe; x.tag = tag;
    expq.push_back(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; we = 1'b0;
    end
  endtask

  // Monitor: result belongs to the request sampled at the previous edge
  always @(posedge clk) sampled <= req_valid && rst_n;

  always @(negedge clk) begin
    if (sampled && expq.size() > 0) begin
      exp_t x;
      x = expq.pop_front();
      check(x.tag, rd_data, err_o, x.d, x.e);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", rd_data, err_o, 32'h0, 1'b0);
    rst_n = 1'b1;

    // R10 / R1: reset word and aliasing of bits 31:29
    issue(0, 32'hFF00_0000, 2, 0, init_of(0, 0), 0, "R10 reset word");
    issue(1, 32'h1F00_0000, 2, 32'hDEAD_BEEF, 0, 0, "R1 write alias");
    issue(0, 32'hFF00_0000, 2, 0, 32'hDEAD_BEEF, 0, "R1 read alias");
    issue(0, 32'h7F00_0000, 2, 0, 32'hDEAD_BEEF, 0, "R1 read alias2");
    // R2: independent slots
    issue(1, 32'hFF00_000C, 2, 32'h1111_2222, 0, 0, "R2 write slot3");
    issue(0, 32'hFF00_0010, 2, 0, init_of(0, 4), 0, "R2 neighbour");
    issue(0, 32'hFF00_000C, 2, 0, 32'h1111_2222, 0, "R2 slot3");
    // R7: narrow accesses
    issue(1, 32'hFF00_000C, 1, 32'hFFFF_ABCD, 0, 0, "R7 half write");
    issue(0, 32'hFF00_000C, 2, 0, 32'h1111_ABCD, 0, "R7 half merge");
    issue(1, 32'hFF00_000C, 0, 32'hFFFF_FF5A, 0, 0, "R7 byte write");
    issue(0, 32'hFF00_000C, 2, 0, 32'h1111_AB5A, 0, "R7 byte merge");
    issue(0, 32'hFF00_000C, 1, 0, 32'h0000_AB5A, 0, "R7 half read");
    issue(0, 32'hFF00_000C, 0, 0, 32'h0000_005A, 0, "R7 byte read");
    // R3: read and write limits differ
    issue(1, 32'hFF00_0040, 2, 32'h1234_5678, 0, 1, "R3 bank0 write over limit");
    issue(0, 32'hFF00_0040, 2, 0, init_of(0, 16), 0, "R3 bank0 read 0x40");
    issue(0, 32'hFF00_0044, 2, 0, init_of(0, 17), 0, "R3 bank0 read limit");
    issue(0, 32'hFFD0_0010, 2, 0, init_of(1, 4), 0, "R3 bank1 read limit");
    issue(1, 32'hFFD0_0010, 2, 32'h5555_5555, 0, 1, "R3 bank1 write over limit");
    issue(0, 32'hFFD0_0010, 2, 0, init_of(1, 4), 0, "R3 bank1 unchanged");
    issue(1, 32'hFFD0_000C, 2, 32'h0000_0077, 0, 0, "R3 bank1 write limit");
    issue(0, 32'hFFD0_000C, 2, 0, 32'h0000_0077, 0, "R3 bank1 readback");
    issue(1, 32'hFFD8_002C, 2, 32'hA5A5_0001, 0, 0, "R3 bank2 write limit");
    issue(0, 32'hFFD8_002C, 2, 0, 32'hA5A5_0001, 0, "R3 bank2 readback");
    // R4: out of range and unknown bank
    issue(0, 32'hFF00_0048, 2, 0, 0, 1, "R4 read over limit");
    issue(0, 32'hFF00_0100, 2, 0, 0, 1, "R4 high offset bits");
    issue(0, 32'hFFE0_0000, 2, 0, 0, 1, "R4 unknown read");
    issue(1, 32'hFFE0_0000, 2, 32'h9, 0, 1, "R4 unknown write");
    issue(1, 32'hFF00_0100, 2, 32'h9, 0, 1, "R4 write high offset");
    issue(0, 32'hFF00_0000, 2, 0, 32'hDEAD_BEEF, 0, "R4 slot0 untouched");
    // R5: no-access slot
    issue(0, 32'hFF00_0004, 2, 0, 0, 0, "R5 read");
    issue(1, 32'hFF00_0004, 2, 32'hFFFF_FFFF, 0, 0, "R5 write");
    issue(0, 32'hFF00_0004, 2, 0, 0, 0, "R5 read after write");
    // R6: constant slot
    issue(0, 32'hFF00_0008, 2, 0, init_of(0, 2), 0, "R6 read");
    issue(1, 32'hFF00_0008, 2, 32'h0BAD_0BAD, 0, 0, "R6 write");
    issue(0, 32'hFF00_0008, 2, 0, init_of(0, 2), 0, "R6 read after write");
    // R8: write-only windows
    issue(1, 32'hFF90_0000, 2, 32'h1234_0000, 0, 0, "R8 write win0");
    issue(0, 32'hFF90_0000, 2, 0, 0, 0, "R8 read win0");
    issue(1, 32'hFF94_0010, 1, 32'h0000_4321, 0, 0, "R8 write win1");
    issue(0, 32'hFF94_0010, 2, 0, 0, 0, "R8 read win1");
    // R9: idle cycle yields quiet outputs
    idle(1);
    @(negedge clk);
    check("R9 idle outputs", rd_data, err_o, 32'h0, 1'b0);
    // R9: back-to-back reads keep their own data
    issue(0, 32'hFFD0_000C, 2, 0, 32'h0000_0077, 0, "R9 b2b first");
    issue(0, 32'hFF00_000C, 2, 0, 32'h1111_AB5A, 0, "R9 b2b second");
    idle(2);
    // R10: mid-run reset restores storage
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 outputs in reset", rd_data, err_o, 32'h0, 1'b0);
    rst_n = 1'b1;
    issue(0, 32'hFF00_000C, 2, 0, init_of(0, 3), 0, "R10 slot3 restored");
    issue(0, 32'hFFD0_000C, 2, 0, init_of(1, 3), 0, "R10 bank1 restored");
    issue(0, 32'hFF00_0000, 2, 0, init_of(0, 0), 0, "R10 slot0 restored");
    idle(3);
    if (expq.size() != 0) begin
      checks++; fails++;
      $display("FAIL R9 scoreboard: got %0d pending, expected 0", expq.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule